// File: doc/BRIEF.md
# SD Host Byte-Wide Register Front End

This block sits between an 8-bit bus master and the core of a small SD host controller. It decodes a 3-bit register address and steers each one-byte access to the right target:
- writes go into the command or data transmit queue;
- reads take one entry from the command-response or data-receive queue;
- reads of the status and timer registers return the current flag and countdown values.

A control register drives the soft-reset input of the controller core. The queues, the command serializer and the data-line engine are separate blocks. They connect through the push, pop, head-data and flag ports of this front end.

Every access is acknowledged exactly once, one clock after the master raises strobe and cycle. Read data is valid during the acknowledge cycle. A queue push or pop fires in that same acknowledge cycle, so the master sees the head of a receive queue before it advances.

Top module: `sdh_regfront`

## Requirements
- R1: For each access with `bus_stb` and `bus_cyc` high, `bus_ack` rises on the next clock edge and stays high for exactly one cycle. It then drops, even if the strobe is still held.
- R2: A write to address 0 pulses `ctq_push` for one cycle, in the acknowledge cycle, with `ctq_data` equal to the written byte.
- R3: A write to address 2 pulses `dtq_push` for one cycle, in the acknowledge cycle, with `dtq_data` equal to the written byte.
- R4: A read of address 1 returns `crq_data` on `bus_rdata` in the acknowledge cycle. It pulses `crq_pop` exactly once in that same cycle.
- R5: A read of address 3 returns `drq_data` on `bus_rdata` in the acknowledge cycle. It pulses `drq_pop` exactly once in that same cycle.
- R6: A read of address 4 returns a status byte with these bits:
  - bit 1 = `crq_empty`;
  - bit 2 = `dtq_full`;
  - bit 3 = `drq_empty`;
  - all other bits 0.
  The flags are sampled on the clock edge that raises the acknowledge.
- R7: A write to address 5 loads bit 0 of the written byte into `core_srst` from the next clock onward (1 asserts soft reset, 0 releases it).
- R8: A read of address 6 returns `timer_val` as sampled on the edge that raises the acknowledge.
- R9: The following accesses are acknowledged and then ignored:
  - reads of addresses 0, 2, 5 or 7;
  - writes to addresses 1, 3, 4, 6 or 7.
  They cause no push and no pop, leave `core_srst` unchanged, and such reads return 0. `bus_rdata` is 0 in every cycle that is not a read acknowledge.
- R10: A synchronous hard reset (`rst` high) clears `core_srst`, `bus_ack`, `bus_rdata` and every push/pop strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high hard reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_stb | input | 1 | Strobe |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 8 | Read data, valid while acknowledged |
| ctq_push | output | 1 | Push into command transmit queue |
| ctq_data | output | 8 | Byte for command transmit queue |
| crq_pop | output | 1 | Pop from command response queue |
| crq_data | input | 8 | Head of command response queue |
| crq_empty | input | 1 | Command response queue empty |
| dtq_push | output | 1 | Push into data transmit queue |
| dtq_data | output | 8 | Byte for data transmit queue |
| dtq_full | input | 1 | Data transmit queue full |
| drq_pop | output | 1 | Pop from data receive queue |
| drq_data | input | 8 | Head of data receive queue |
| drq_empty | input | 1 | Data receive queue empty |
| timer_val | input | 8 | Timeout countdown value |
| core_srst | output | 1 | Soft reset to the controller core |

## Verification
On every cycle, the assertions check the following:
- the acknowledge is a single-cycle pulse that follows a request;
- at most one queue strobe fires at a time, and only in an acknowledge cycle of the correct direction;
- the status and timer bytes match the values sampled one edge earlier;
- the control bit follows a control write and otherwise holds.

Only the bench's scenarios can show the rest:
- each decoded address produces the full expected combination of read byte and strobes;
- every wrong-direction or undefined access leaves soft reset untouched;
- a hard reset clears a soft reset that was asserted earlier.

// File: rtl/sdh_regfront_pkg.sv
package sdh_regfront_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CMD_TX  = 3'd0,
        SEL_CMD_RSP = 3'd1,
        SEL_DAT_TX  = 3'd2,
        SEL_DAT_RX  = 3'd3,
        SEL_STATUS  = 3'd4,
        SEL_CTRL    = 3'd5,
        SEL_TIMER   = 3'd6,
        SEL_UNUSED  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic push_cmd;
        logic pop_rsp;
        logic push_dat;
        logic pop_rx;
        logic load_ctrl;
    } strobes_t;

    localparam int ST_RSP_EMPTY_BIT = 1;
    localparam int ST_DTX_FULL_BIT  = 2;
    localparam int ST_DRX_EMPTY_BIT = 3;
    localparam int CTRL_SRST_BIT    = 0;

    // Decode one access into side-effect strobes; wrong direction gives none.
    function automatic strobes_t decode_access(input logic [REG_ADDR_W-1:0] addr,
                                               input logic we);
        strobes_t s;
        s = '0;
        case (reg_sel_e'(addr))
            SEL_CMD_TX:  s.push_cmd  = we;
            SEL_CMD_RSP: s.pop_rsp   = ~we;
            SEL_DAT_TX:  s.push_dat  = we;
            SEL_DAT_RX:  s.pop_rx    = ~we;
            SEL_CTRL:    s.load_ctrl = we;
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdh_bus_handshake.sv
module sdh_bus_handshake (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic cyc,
    output logic ack,
    output logic req
);

    assign req = stb & cyc & ~ack;

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= req;
    end

    // R1: acknowledge lasts one cycle
    assert_ack_single_R1: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R1: acknowledge only follows a strobed cycle
    assert_ack_after_req_R1: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(stb && cyc));

endmodule

// File: rtl/sdh_read_path.sv
module sdh_read_path
    import sdh_regfront_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     rsp_head,
    input  logic [DATA_W-1:0]     rx_head,
    input  logic [DATA_W-1:0]     timer,
    input  logic [DATA_W-1:0]     status,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] sel_val;

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_CMD_RSP: sel_val = rsp_head;
            SEL_DAT_RX:  sel_val = rx_head;
            SEL_STATUS:  sel_val = status;
            SEL_TIMER:   sel_val = timer;
            default:     sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !cap) rdata <= '0;
        else             rdata <= sel_val;
    end

    // R9: read bus is quiet unless a read was captured on the previous edge
    assert_rdata_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(cap) |-> rdata == '0);

    // R9: undefined and write-only addresses read back as zero
    assert_undef_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(cap) && ($past(addr) == SEL_UNUSED || $past(addr) == SEL_CTRL ||
                        $past(addr) == SEL_CMD_TX || $past(addr) == SEL_DAT_TX))
        |-> rdata == '0);

endmodule

// File: rtl/sdh_ctrl_reg.sv
module sdh_ctrl_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic bit_in,
    output logic srst
);

    always_ff @(posedge clk) begin
        if (rst)     srst <= 1'b0;
        else if (wr) srst <= bit_in;
    end

    // R7: control write takes effect on the next clock
    assert_ctrl_load_R7: assert property (@(posedge clk) disable iff (rst)
        wr |=> srst == $past(bit_in));

    // R9: without a control write the soft reset holds
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(srst));

endmodule

// File: rtl/sdh_regfront.sv
module sdh_regfront
    import sdh_regfront_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_stb,
    input  logic                  bus_cyc,
    output logic                  bus_ack,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  ctq_push,
    output logic [DATA_W-1:0]     ctq_data,
    output logic                  crq_pop,
    input  logic [DATA_W-1:0]     crq_data,
    input  logic                  crq_empty,
    output logic                  dtq_push,
    output logic [DATA_W-1:0]     dtq_data,
    input  logic                  dtq_full,
    output logic                  drq_pop,
    input  logic [DATA_W-1:0]     drq_data,
    input  logic                  drq_empty,
    input  logic [DATA_W-1:0]     timer_val,
    output logic                  core_srst
);

    localparam int STATUS_MSB = ST_DRX_EMPTY_BIT;

    logic              req;
    logic              rd_cap;
    strobes_t          strb;
    logic [DATA_W-1:0] status_byte;

    sdh_bus_handshake u_hs (
        .clk (clk),
        .rst (rst),
        .stb (bus_stb),
        .cyc (bus_cyc),
        .ack (bus_ack),
        .req (req)
    );

    assign rd_cap = req & ~bus_we;

    // Status byte: fixed flag positions, unused positions zero.
    always_comb begin
        status_byte = '0;
        status_byte[ST_RSP_EMPTY_BIT] = crq_empty;
        status_byte[ST_DTX_FULL_BIT]  = dtq_full;
        status_byte[ST_DRX_EMPTY_BIT] = drq_empty;
    end

    sdh_read_path #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .cap      (rd_cap),
        .addr     (bus_addr),
        .rsp_head (crq_data),
        .rx_head  (drq_data),
        .timer    (timer_val),
        .status   (status_byte),
        .rdata    (bus_rdata)
    );

    assign strb     = bus_ack ? decode_access(bus_addr, bus_we) : '0;
    assign ctq_push = strb.push_cmd;
    assign crq_pop  = strb.pop_rsp;
    assign dtq_push = strb.push_dat;
    assign drq_pop  = strb.pop_rx;
    assign ctq_data = bus_wdata;
    assign dtq_data = bus_wdata;

    sdh_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (strb.load_ctrl),
        .bit_in (bus_wdata[CTRL_SRST_BIT]),
        .srst   (core_srst)
    );

    // R2, R3, R4, R5: at most one queue strobe per cycle
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctq_push, crq_pop, dtq_push, drq_pop}));

    // R2: command push only from a strobed write to address 0
    assert_cmd_push_src_R2: assert property (@(posedge clk) disable iff (rst)
        ctq_push |-> $past(bus_stb && bus_cyc && bus_we && bus_addr == SEL_CMD_TX));

    // R3: data push only from a strobed write to address 2
    assert_dat_push_src_R3: assert property (@(posedge clk) disable iff (rst)
        dtq_push |-> $past(bus_stb && bus_cyc && bus_we && bus_addr == SEL_DAT_TX));

    // R4: response pop only from a strobed read of address 1
    assert_rsp_pop_src_R4: assert property (@(posedge clk) disable iff (rst)
        crq_pop |-> $past(bus_stb && bus_cyc && !bus_we && bus_addr == SEL_CMD_RSP));

    // R5: receive pop only from a strobed read of address 3
    assert_rx_pop_src_R5: assert property (@(posedge clk) disable iff (rst)
        drq_pop |-> $past(bus_stb && bus_cyc && !bus_we && bus_addr == SEL_DAT_RX));

    // R6: status read reflects the flags sampled at the request edge
    assert_status_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_we && bus_addr == SEL_STATUS) |->
        (bus_rdata[STATUS_MSB:0] == {$past(drq_empty), $past(dtq_full), $past(crq_empty), 1'b0}
         && bus_rdata[DATA_W-1:STATUS_MSB+1] == '0));

    // R8: timer read returns the sampled countdown
    assert_timer_read_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !bus_we && bus_addr == SEL_TIMER) |-> bus_rdata == $past(timer_val));

endmodule

// File: tb/sdh_regfront_bench.sv
module sdh_regfront_bench;

    typedef struct packed {
        logic [7:0] rdata;
        logic [3:0] strb;   // {ctq_push, crq_pop, dtq_push, drq_pop}
        logic [7:0] wd;
        logic       we;
        logic [7:0] req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0, bus_stb = 1'b0, bus_cyc = 1'b0;
    logic       bus_ack;
    logic [7:0] bus_rdata;
    logic       ctq_push, crq_pop, dtq_push, drq_pop, core_srst;
    logic [7:0] ctq_data, dtq_data;
    logic [7:0] crq_data = '0, drq_data = '0, timer_val = '0;
    logic       crq_empty = 1'b0, dtq_full = 1'b0, drq_empty = 1'b0;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    sdh_regfront u_sdh_regfront (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_stb(bus_stb), .bus_cyc(bus_cyc), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .ctq_push(ctq_push), .ctq_data(ctq_data),
        .crq_pop(crq_pop), .crq_data(crq_data), .crq_empty(crq_empty),
        .dtq_push(dtq_push), .dtq_data(dtq_data), .dtq_full(dtq_full),
        .drq_pop(drq_pop), .drq_data(drq_data), .drq_empty(drq_empty),
        .timer_val(timer_val), .core_srst(core_srst)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compares every acknowledge against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (bus_ack) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected ack", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(bus_rdata == e.rdata, $sformatf("R%0d rdata", e.req), bus_rdata, e.rdata);
                    check({ctq_push, crq_pop, dtq_push, drq_pop} == e.strb,
                          $sformatf("R%0d strobes", e.req),
                          {ctq_push, crq_pop, dtq_push, drq_pop}, e.strb);
                    if (e.strb[3]) check(ctq_data == e.wd, "R2 push data", ctq_data, e.wd);
                    if (e.strb[1]) check(dtq_data == e.wd, "R3 push data", dtq_data, e.wd);
                end
            end else if ({ctq_push, crq_pop, dtq_push, drq_pop} != 4'b0) begin
                check(1'b0, "R9 strobe outside ack", {ctq_push, crq_pop, dtq_push, drq_pop}, 0);
            end
        end
    end

    // Driver: queues the expectation, runs one access, checks the ack drops.
    task automatic access(input logic [2:0] a, input logic w, input logic [7:0] d,
                          input logic [7:0] exp_rd, input logic [3:0] exp_strb, input int req);
        exp_t e;
        e.rdata = exp_rd; e.strb = exp_strb; e.wd = d; e.we = w; e.req = 8'(req);
        sb.push_back(e);
        @(posedge clk); #1;
        bus_addr = a; bus_we = w; bus_wdata = d; bus_stb = 1'b1; bus_cyc = 1'b1;
        @(posedge clk); #1;
        check(bus_ack == 1'b1, "R1 ack one cycle after strobe", bus_ack, 1);
        @(posedge clk); #1;
        check(bus_ack == 1'b0, "R1 ack drops after one cycle", bus_ack, 0);
        bus_stb = 1'b0; bus_cyc = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R10: reset state
        check(bus_ack == 0 && bus_rdata == 0 && core_srst == 0, "R10 reset state",
              {bus_ack, bus_rdata, core_srst}, 0);

        // R1 strobe held two cycles: single ack only
        access(3'd0, 1'b1, 8'h40, 8'h00, 4'b1000, 2);   // R2
        access(3'd0, 1'b1, 8'h48, 8'h00, 4'b1000, 2);   // R2 second pattern
        access(3'd2, 1'b1, 8'hA5, 8'h00, 4'b0010, 3);   // R3
        access(3'd2, 1'b1, 8'h00, 8'h00, 4'b0010, 3);   // R3 zero byte
        crq_data = 8'h3C;
        access(3'd1, 1'b0, 8'h00, 8'h3C, 4'b0100, 4);   // R4
        crq_data = 8'hC2;
        access(3'd1, 1'b0, 8'h00, 8'hC2, 4'b0100, 4);   // R4
        drq_data = 8'h96;
        access(3'd3, 1'b0, 8'h00, 8'h96, 4'b0001, 5);   // R5
        drq_data = 8'h29;
        access(3'd3, 1'b0, 8'h00, 8'h29, 4'b0001, 5);   // R5

        // R6: every flag combination
        for (int k = 0; k < 8; k++) begin
            crq_empty = k[0]; dtq_full = k[1]; drq_empty = k[2];
            access(3'd4, 1'b0, 8'h00, {4'b0, k[2], k[1], k[0], 1'b0}, 4'b0000, 6);
        end

        // R8: timer readback
        timer_val = 8'hFF; access(3'd6, 1'b0, 8'h00, 8'hFF, 4'b0000, 8);
        timer_val = 8'h5A; access(3'd6, 1'b0, 8'h00, 8'h5A, 4'b0000, 8);
        timer_val = 8'h00; access(3'd6, 1'b0, 8'h00, 8'h00, 4'b0000, 8);

        // R7: control bit 0 drives soft reset
        access(3'd5, 1'b1, 8'h01, 8'h00, 4'b0000, 7);
        check(core_srst == 1'b1, "R7 soft reset asserted", core_srst, 1);
        access(3'd5, 1'b1, 8'hFE, 8'h00, 4'b0000, 7);
        check(core_srst == 1'b0, "R7 soft reset released by bit0=0", core_srst, 0);
        access(3'd5, 1'b1, 8'h01, 8'h00, 4'b0000, 7);
        check(core_srst == 1'b1, "R7 soft reset asserted again", core_srst, 1);

        // R9: wrong direction and undefined address are ignored
        crq_data = 8'h77; drq_data = 8'h88; timer_val = 8'h99;
        crq_empty = 1; dtq_full = 1; drq_empty = 1;
        access(3'd5, 1'b0, 8'h00, 8'h00, 4'b0000, 9);   // read of control
        access(3'd0, 1'b0, 8'h00, 8'h00, 4'b0000, 9);   // read of cmd tx
        access(3'd2, 1'b0, 8'h00, 8'h00, 4'b0000, 9);   // read of data tx
        access(3'd7, 1'b0, 8'h00, 8'h00, 4'b0000, 9);   // undefined read
        access(3'd1, 1'b1, 8'h00, 8'h00, 4'b0000, 9);   // write to rsp queue
        access(3'd3, 1'b1, 8'h00, 8'h00, 4'b0000, 9);   // write to rx queue
        access(3'd4, 1'b1, 8'h00, 8'h00, 4'b0000, 9);   // write to status
        access(3'd6, 1'b1, 8'h00, 8'h00, 4'b0000, 9);   // write to timer
        access(3'd7, 1'b1, 8'h00, 8'h00, 4'b0000, 9);   // undefined write
        check(core_srst == 1'b1, "R9 soft reset unchanged by ignored accesses", core_srst, 1);

        // R10: hard reset clears an asserted soft reset
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check(core_srst == 1'b0, "R10 hard reset clears soft reset", core_srst, 0);
        check(bus_ack == 1'b0 && bus_rdata == 8'h00, "R10 bus outputs cleared",
              {bus_ack, bus_rdata}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(sb.size() == 0, "R1 every access acknowledged", sb.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule